// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of the instruction sitting in decode, whether the value should come from the register file or be taken early from one of the two instructions ahead of it. The younger of those two is in the execute stage. Its live ALU result is used. The older one is in the memory stage. Its stage output is used, and that output is load data for a load and the ALU result for anything else.

The selection logic is combinational. The chosen values drive the operand A and B registers that sit at the boundary into execute. Those registers load on each rising clock edge unless the hold input is high.

The register file, the ALU and the logic that decides when to stall all live outside this block.

Top module: `opnd_bypass_unit`

## Requirements
- R1: When neither older instruction is a valid producer for a source field, that operand's select code is 00 and its next value equals the register-file read data. Select code 11 never appears.
- R2: Operand A takes select 01 and the execute-stage ALU result when dec_rs equals ex_dst, ex_dst is nonzero and ex_wen is 1.
- R3: When R2 does not apply, operand A takes select 10 and the memory-stage value when dec_rs equals mem_dst, mem_dst is nonzero and mem_wen is 1.
- R4: If both older instructions write the source register, the execute-stage producer (select 01) wins over the memory-stage producer.
- R5: A source field of 0 always selects 00, whatever the destination numbers and write enables are.
- R6: The select-10 value is mem_load_data when mem_is_load is 1 and mem_alu_res when mem_is_load is 0.
- R7: Operand B follows the rules of R1 through R6 using dec_rt. It is computed independently of operand A.
- R8: On a rising edge with hold at 0, opnd_a_q and opnd_b_q load the next values. With hold at 1 they keep their previous contents.
- R9: While rst_n is low, opnd_a_q and opnd_b_q read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the operand registers |
| hold | input | 1 | Keeps the operand registers unchanged for the cycle |
| dec_rs | input | REG_AW | First source register number of the decoding instruction |
| dec_rt | input | REG_AW | Second source register number of the decoding instruction |
| ex_dst | input | REG_AW | Destination number of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | REG_AW | Destination number of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction returns load data |
| rf_rd_a | input | DATA_W | Register-file read data for the first source |
| rf_rd_b | input | DATA_W | Register-file read data for the second source |
| ex_alu_res | input | DATA_W | Live ALU result in execute |
| mem_alu_res | input | DATA_W | ALU result held in the memory stage |
| mem_load_data | input | DATA_W | Load data returned in the memory stage |
| sel_a | output | 2 | Select code for operand A |
| sel_b | output | 2 | Select code for operand B |
| opnd_a_nxt | output | DATA_W | Chosen value for operand A |
| opnd_b_nxt | output | DATA_W | Chosen value for operand B |
| opnd_a_q | output | DATA_W | Operand A register |
| opnd_b_q | output | DATA_W | Operand B register |

## Verification
The bench sweeps every combination of source number, both destination numbers, both write enables and the load flag on a small register space. This covers back-to-back dependencies, distance-two dependencies and double matches.

A priority inversion would hand a consumer stale data from the older producer, and the double-match cases expose it. A missing zero test would forward a write to register 0 as if it were real, and the zero-source cases catch that. A swapped load flag would return the ALU address in place of the loaded word.

Hold is asserted on a regular pattern in the same sweep. A register that ignored hold would therefore show a changed value on the next edge.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_EX  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/bypass_select.sv
module bypass_select
  import opnd_bypass_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  output logic              ex_hit,
  output logic              mem_hit,
  output fwd_sel_e          sel
);

  // A producer matches only a nonzero register it really writes.
  function automatic logic producer_hit(input logic [REG_AW-1:0] s,
                                        input logic [REG_AW-1:0] d,
                                        input logic              we);
    return we && (d != '0) && (s == d);
  endfunction

  assign ex_hit  = producer_hit(src, ex_dst, ex_wen);
  assign mem_hit = producer_hit(src, mem_dst, mem_wen);

  // The younger producer wins.
  always_comb begin
    if (ex_hit)       sel = SEL_EX;
    else if (mem_hit) sel = SEL_MEM;
    else              sel = SEL_RF;
  end

endmodule

// File: rtl/bypass_mux.sv
module bypass_mux
  import opnd_bypass_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] ex_val,
  input  logic [DATA_W-1:0] mem_val,
  output logic [DATA_W-1:0] out
);

  always_comb begin
    unique case (sel)
      SEL_EX:  out = ex_val;
      SEL_MEM: out = mem_val;
      default: out = rf_val;
    endcase
  end

endmodule

// File: rtl/operand_reg.sv
module operand_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (!hold) q <= d;
  end

endmodule

// File: rtl/opnd_bypass_unit.sv
module opnd_bypass_unit
  import opnd_bypass_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [REG_AW-1:0] dec_rs,
  input  logic [REG_AW-1:0] dec_rt,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic              mem_is_load,
  input  logic [DATA_W-1:0] rf_rd_a,
  input  logic [DATA_W-1:0] rf_rd_b,
  input  logic [DATA_W-1:0] ex_alu_res,
  input  logic [DATA_W-1:0] mem_alu_res,
  input  logic [DATA_W-1:0] mem_load_data,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a_nxt,
  output logic [DATA_W-1:0] opnd_b_nxt,
  output logic [DATA_W-1:0] opnd_a_q,
  output logic [DATA_W-1:0] opnd_b_q
);

  function automatic logic [DATA_W-1:0] mem_stage_value(input logic              is_load,
                                                        input logic [DATA_W-1:0] ld,
                                                        input logic [DATA_W-1:0] alu);
    return is_load ? ld : alu;
  endfunction

  logic [DATA_W-1:0] mem_val;
  logic [REG_AW-1:0] src_w [NUM_OPND];
  logic [DATA_W-1:0] rf_w  [NUM_OPND];
  logic [DATA_W-1:0] nxt_w [NUM_OPND];
  logic [DATA_W-1:0] q_w   [NUM_OPND];
  fwd_sel_e          sel_w [NUM_OPND];
  logic              ex_hit_w  [NUM_OPND];
  logic              mem_hit_w [NUM_OPND];

  // Named event wires, observed by the checker.
  logic ex_hit_a, ex_hit_b, mem_hit_a, mem_hit_b;

  assign mem_val  = mem_stage_value(mem_is_load, mem_load_data, mem_alu_res);
  assign src_w[0] = dec_rs;
  assign src_w[1] = dec_rt;
  assign rf_w[0]  = rf_rd_a;
  assign rf_w[1]  = rf_rd_b;

  for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
    bypass_select #(.REG_AW(REG_AW)) u_sel (
      .src    (src_w[i]),
      .ex_dst (ex_dst),
      .ex_wen (ex_wen),
      .mem_dst(mem_dst),
      .mem_wen(mem_wen),
      .ex_hit (ex_hit_w[i]),
      .mem_hit(mem_hit_w[i]),
      .sel    (sel_w[i])
    );

    bypass_mux #(.DATA_W(DATA_W)) u_mux (
      .sel    (sel_w[i]),
      .rf_val (rf_w[i]),
      .ex_val (ex_alu_res),
      .mem_val(mem_val),
      .out    (nxt_w[i])
    );

    operand_reg #(.DATA_W(DATA_W)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .hold (hold),
      .d    (nxt_w[i]),
      .q    (q_w[i])
    );
  end

  assign sel_a      = sel_w[0];
  assign sel_b      = sel_w[1];
  assign opnd_a_nxt = nxt_w[0];
  assign opnd_b_nxt = nxt_w[1];
  assign opnd_a_q   = q_w[0];
  assign opnd_b_q   = q_w[1];
  assign ex_hit_a   = ex_hit_w[0];
  assign ex_hit_b   = ex_hit_w[1];
  assign mem_hit_a  = mem_hit_w[0];
  assign mem_hit_b  = mem_hit_w[1];

endmodule

// File: rtl/opnd_bypass_unit_chk.sv
module opnd_bypass_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic [REG_AW-1:0] dec_rs,
  input logic [REG_AW-1:0] dec_rt,
  input logic [REG_AW-1:0] ex_dst,
  input logic              ex_wen,
  input logic [REG_AW-1:0] mem_dst,
  input logic              mem_wen,
  input logic              mem_is_load,
  input logic [DATA_W-1:0] mem_alu_res,
  input logic [DATA_W-1:0] mem_load_data,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a_nxt,
  input logic [DATA_W-1:0] opnd_a_q,
  input logic [DATA_W-1:0] opnd_b_nxt,
  input logic [DATA_W-1:0] opnd_b_q,
  input logic              ex_hit_a,
  input logic              ex_hit_b,
  input logic              mem_hit_a,
  input logic              mem_hit_b
);

  a_r1_no_code_11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'b11) && (sel_b != 2'b11));

  a_r4_younger_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_hit_a && mem_hit_a) |-> (sel_a == 2'b01));

  a_r3_mem_source: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'b10) |-> (mem_wen && (mem_dst == dec_rs) && (dec_rs != '0) && !ex_hit_a));

  a_r5_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rs == '0) |-> (sel_a == 2'b00 && !ex_hit_a && !mem_hit_a));

  a_r2_ex_source: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'b01) |-> (ex_wen && (ex_dst == dec_rs)));

  a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'b10 && mem_is_load) |-> (opnd_a_nxt == mem_load_data));

  a_r6_alu_value: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'b10 && !mem_is_load) |-> (opnd_a_nxt == mem_alu_res));

  a_r7_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rt == '0) |-> (sel_b == 2'b00 && !ex_hit_b && !mem_hit_b));

  a_r8_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(opnd_a_q) && $stable(opnd_b_q)));

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (opnd_a_q == $past(opnd_a_nxt) && opnd_b_q == $past(opnd_b_nxt)));

endmodule

bind opnd_bypass_unit opnd_bypass_unit_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .dec_rs(dec_rs), .dec_rt(dec_rt),
  .ex_dst(ex_dst), .ex_wen(ex_wen), .mem_dst(mem_dst), .mem_wen(mem_wen),
  .mem_is_load(mem_is_load), .mem_alu_res(mem_alu_res), .mem_load_data(mem_load_data),
  .sel_a(sel_a), .sel_b(sel_b), .opnd_a_nxt(opnd_a_nxt), .opnd_a_q(opnd_a_q),
  .opnd_b_nxt(opnd_b_nxt), .opnd_b_q(opnd_b_q),
  .ex_hit_a(ex_hit_a), .ex_hit_b(ex_hit_b), .mem_hit_a(mem_hit_a), .mem_hit_b(mem_hit_b)
);

// File: tb/opnd_bypass_unit_bench.sv
module opnd_bypass_unit_bench;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 3;
  localparam int unsigned NR = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold = 1'b0;
  logic [AW-1:0] dec_rs = '0, dec_rt = '0, ex_dst = '0, mem_dst = '0;
  logic          ex_wen = 1'b0, mem_wen = 1'b0, mem_is_load = 1'b0;
  logic [DW-1:0] rf_rd_a = '0, rf_rd_b = '0, ex_alu_res = '0, mem_alu_res = '0, mem_load_data = '0;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opnd_a_nxt, opnd_b_nxt, opnd_a_q, opnd_b_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  opnd_bypass_unit #(.DATA_W(DW), .REG_AW(AW)) u_opnd_bypass_unit (
    .clk(clk), .rst_n(rst_n), .hold(hold), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .mem_dst(mem_dst), .mem_wen(mem_wen),
    .mem_is_load(mem_is_load), .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b),
    .ex_alu_res(ex_alu_res), .mem_alu_res(mem_alu_res), .mem_load_data(mem_load_data),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a_nxt(opnd_a_nxt), .opnd_b_nxt(opnd_b_nxt),
    .opnd_a_q(opnd_a_q), .opnd_b_q(opnd_b_q)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected select code, written as a score: a younger match beats an older one.
  function automatic logic [1:0] want_sel(input logic [AW-1:0] s,
                                          input logic [AW-1:0] ed, input logic ew,
                                          input logic [AW-1:0] md, input logic mw);
    int score;
    score = 0;
    if (s != 0 && mw && md == s) score = 2;
    if (s != 0 && ew && ed == s) score = 1;
    return 2'(score);
  endfunction

  function automatic logic [DW-1:0] want_val(input logic [1:0] code, input logic [DW-1:0] rf);
    if (code == 2'd1) return ex_alu_res;
    if (code == 2'd2) return mem_is_load ? mem_load_data : mem_alu_res;
    return rf;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [1:0]    ea, eb;
    logic [DW-1:0] va, vb, qa_prev, qb_prev;
    int            idx;
    string         ra;

    ex_alu_res    = 32'hE0E0_0001;
    mem_alu_res   = 32'h3A3A_0002;
    mem_load_data = 32'h4D4D_0003;
    repeat (3) @(negedge clk);
    // R9: registers cleared while reset is low
    check("R9", "opnd_a_q in reset", opnd_a_q, '0);
    check("R9", "opnd_b_q in reset", opnd_b_q, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep covering back-to-back (R2), distance-two (R3), double match (R4),
    // register 0 (R5), load vs ALU value (R6), operand B (R7) and hold (R8).
    idx = 0;
    for (int rs = 0; rs < NR; rs++)
      for (int ed = 0; ed < NR; ed++)
        for (int md = 0; md < NR; md++)
          for (int fl = 0; fl < 8; fl++) begin
            @(negedge clk);
            qa_prev     = opnd_a_q;
            qb_prev     = opnd_b_q;
            dec_rs      = AW'(rs);
            dec_rt      = AW'(rs + ed + fl);
            ex_dst      = AW'(ed);
            mem_dst     = AW'(md);
            ex_wen      = fl[0];
            mem_wen     = fl[1];
            mem_is_load = fl[2];
            rf_rd_a     = 32'hAA00_0000 | rs;
            rf_rd_b     = 32'hBB00_0000 | 32'(dec_rt);
            ex_alu_res  = 32'hE000_0000 | 32'(idx);
            hold        = (idx % 5 == 3);
            #1;
            ea = want_sel(dec_rs, ex_dst, ex_wen, mem_dst, mem_wen);
            eb = want_sel(dec_rt, ex_dst, ex_wen, mem_dst, mem_wen);
            va = want_val(ea, rf_rd_a);
            vb = want_val(eb, rf_rd_b);
            if (rs == 0)                               ra = "R5";
            else if (ea == 2'd1 && md == ed && fl[1])  ra = "R4";
            else if (ea == 2'd1)                       ra = "R2";
            else if (ea == 2'd2)                       ra = (fl[2] ? "R6" : "R3");
            else                                       ra = "R1";
            check(ra,   "sel_a",      32'(sel_a), 32'(ea));
            check(ra,   "opnd_a_nxt", opnd_a_nxt, va);
            check("R7", "sel_b",      32'(sel_b), 32'(eb));
            check("R7", "opnd_b_nxt", opnd_b_nxt, vb);
            @(posedge clk);
            #1;
            check("R8", "opnd_a_q", opnd_a_q, hold ? qa_prev : va);
            check("R8", "opnd_b_q", opnd_b_q, hold ? qb_prev : vb);
            idx++;
          end

    done = 1'b1;
    summary();
  end

endmodule